// File: doc/BRIEF.md
# Line Read Sequencer

This block produces the read timing for a line memory that holds time-base-corrected video. Everything runs on one reference sampling clock at four times the colour subcarrier. A line address counter picks which of sixteen stored lines is read. A reference vertical pulse loads it with a chosen start line. Each reference horizontal pulse then moves it on by one line, and it wraps after the last line.

Within a line, a rotating one-hot register produces sixteen byte enables. Each enable picks one byte of the current wide memory word to drive the output bus. A reference horizontal pulse, or a separate start-read pulse, puts the single active bit back on the first enable. The start-read pulse realigns the byte phase within a line without moving the line address.

While the last enable is active, the block raises a word-read request. The next wide word is then fetched by the time the rotation comes back to the first enable. The memory itself sits outside this block.

Top module: `line_read_seq`

## Requirements
- R1: After reset, `line_addr` is 0, all bits of `oe` are 0 and `sw_req` is 0.
- R2: Until the first clock edge with `ref_h` or `start_read` high, `oe` stays all zero whatever `ref_v` and `v_preset` do.
- R3: A clock edge with `ref_h` or `start_read` high makes `oe` equal to 1, with only bit 0 (the first enable) set.
- R4: On a clock edge with neither `ref_h` nor `start_read`, a nonzero `oe` moves its set bit from bit i to bit i+1, and from bit 15 back to bit 0.
- R5: On every clock after the first preset edge of R3, exactly one bit of `oe` is set.
- R6: A clock edge with `ref_v` high loads `line_addr` from `v_preset`. This holds even when `ref_h` is high in the same cycle.
- R7: A clock edge with `ref_h` high and `ref_v` low advances `line_addr` by one, and 15 wraps to 0.
- R8: `start_read` alone does not change `line_addr`. With `ref_v` and `ref_h` both low, `line_addr` holds.
- R9: `sw_req` is high exactly while bit 15 of `oe` is set. This is the clock just before rotation returns to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sample clock, four times subcarrier |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_h | input | 1 | Reference horizontal pulse, one clock wide |
| ref_v | input | 1 | Reference vertical pulse, one clock wide |
| start_read | input | 1 | Start-read pulse that realigns the byte enables |
| v_preset | input | 4 | Line address loaded on `ref_v` |
| line_addr | output | 4 | Read line address |
| oe | output | 16 | One-hot byte enables; bit 0 is the first |
| sw_req | output | 1 | Wide-word read request |

## Verification
The bench builds the block with its default sixteen lines and sixteen byte enables. It can therefore follow the rotation through a full turn, including the request on the last enable and the return to the first. Sixteen horizontal pulses in a row bring the address wrap from 15 to 0 within reach. Random stimulus also hits the cases where a preset lands in the middle of a rotation, and where vertical and horizontal pulses arrive together.

// File: rtl/line_read_seq.sv
module line_read_seq #(
  parameter int LINES = 16,
  parameter int BYTES = 16,
  localparam int AW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_h,
  input  logic          ref_v,
  input  logic          start_read,
  input  logic [AW-1:0] v_preset,
  output logic [AW-1:0] line_addr,
  output logic [BYTES-1:0] oe,
  output logic          sw_req
);

  localparam logic [AW-1:0] LAST_LINE = AW'(LINES - 1);

  logic realign;
  assign realign = ref_h | start_read;

  always_ff @(posedge clk) begin
    if (!rst_n)
      line_addr <= '0;
    else if (ref_v)
      line_addr <= v_preset;
    else if (ref_h)
      line_addr <= (line_addr == LAST_LINE) ? '0 : line_addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      oe <= '0;
    else if (realign)
      oe <= BYTES'(1);
    else if (|oe)
      oe <= {oe[BYTES-2:0], oe[BYTES-1]};
  end

  assign sw_req = oe[BYTES-1];

endmodule

// File: rtl/line_read_seq_chk.sv
module line_read_seq_chk #(
  parameter int LINES = 16,
  parameter int BYTES = 16,
  localparam int AW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_h,
  input logic          ref_v,
  input logic          start_read,
  input logic [AW-1:0] v_preset,
  input logic [AW-1:0] line_addr,
  input logic [BYTES-1:0] oe,
  input logic          sw_req
);

  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else if (ref_h || start_read) seen <= 1'b1;
  end

  assert_idle_before_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> oe == '0);

  assert_preset_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_h || start_read) |=> oe == BYTES'(1));

  assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_h && !start_read && oe != '0) |=>
      oe == {$past(oe[BYTES-2:0]), $past(oe[BYTES-1])});

  assert_one_hot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> $countones(oe) == 1);

  assert_vertical_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_v |=> line_addr == $past(v_preset));

  assert_line_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_h && !ref_v) |=>
      line_addr == (($past(line_addr) == AW'(LINES - 1)) ? '0 : AW'($past(line_addr) + 1'b1)));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_h && !ref_v) |=> $stable(line_addr));

  assert_req_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> oe[0]);

endmodule

bind line_read_seq line_read_seq_chk #(.LINES(LINES), .BYTES(BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_h(ref_h), .ref_v(ref_v), .start_read(start_read),
  .v_preset(v_preset), .line_addr(line_addr), .oe(oe), .sw_req(sw_req)
);

// File: tb/line_read_seq_tb.sv
module line_read_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int BYTES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_h = 1'b0, ref_v = 1'b0, start_read = 1'b0;
  logic [3:0] v_preset = '0;
  logic [3:0] line_addr;
  logic [15:0] oe;
  logic sw_req;

  int checks = 0;
  int fails = 0;
  logic [3:0] m_addr;
  logic [15:0] m_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_read_seq #(.LINES(LINES), .BYTES(BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_h(ref_h), .ref_v(ref_v), .start_read(start_read),
    .v_preset(v_preset), .line_addr(line_addr), .oe(oe), .sw_req(sw_req)
  );

  function automatic logic [3:0] next_addr(logic [3:0] a, logic h, logic v, logic [3:0] p);
    if (v) return p;
    if (h) return (a == 4'd15) ? 4'd0 : a + 4'd1;
    return a;
  endfunction

  function automatic logic [15:0] next_oe(logic [15:0] o, logic h, logic s);
    if (h || s) return 16'h0001;
    if (o == 16'h0) return o;
    return {o[14:0], o[15]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic h, input logic v, input logic s, input logic [3:0] p,
                      input bit started);
    string at, ot;
    ref_h = h; ref_v = v; start_read = s; v_preset = p;
    @(posedge clk);
    m_addr = next_addr(m_addr, h, v, p);
    m_oe = next_oe(m_oe, h, s);
    @(negedge clk);
    at = v ? "R6 addr load" : (h ? "R7 addr step" : "R8 addr hold");
    ot = (h || s) ? "R3 preset" : (started ? "R4 rotate" : "R2 idle");
    chk(at, line_addr, m_addr);
    chk(ot, oe, m_oe);
    chk("R9 word request", sw_req, m_oe[15]);
    if (started || h || s) chk("R5 one enable", $countones(oe), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7301));
    m_addr = '0; m_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset addr", line_addr, 0);
    chk("R1 reset oe", oe, 0);
    chk("R1 reset req", sw_req, 0);

    // R2: vertical pulses before any preset leave enables idle
    step(0, 1, 0, 4'd9, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 4'd0, 0);

    // R3/R4/R9: full rotation
    step(1, 0, 0, 4'd0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 4'd0, 1);

    // R6 priority over ref_h
    step(1, 1, 0, 4'd5, 1);
    chk("R6 priority", line_addr, 5);

    // R7 wrap
    for (int i = 0; i < 12; i++) step(1, 0, 0, 4'd0, 1);
    chk("R7 wrap", line_addr, 1);

    // R8: start_read mid line realigns without moving address
    for (int i = 0; i < 7; i++) step(0, 0, 0, 4'd0, 1);
    step(0, 0, 1, 4'd0, 1);
    chk("R8 start_read addr", line_addr, 1);
    chk("R3 start_read oe", oe, 16'h0001);

    for (int i = 0; i < 3000; i++) begin
      logic h, v, s;
      h = ($urandom % 19) == 0;
      v = ($urandom % 97) == 0;
      s = ($urandom % 41) == 0;
      step(h, v, s, 4'($urandom), 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule